// File: doc/BRIEF.md
# Extended Indirect Bank Translator

This unit sits on the bus between an 8-bit CPU and a paged memory system. Whenever the CPU reads a byte from zero page during a data cycle, and the zero-page register points at one of the pages set aside for extended pointers, the unit captures a companion "extension byte". Memory returns that byte from a shadow address derived from the zero-page base. The captured byte selects an extended bank. The data cycles that follow in the same instruction, and that fall outside zero page, are then redirected into that bank.

The bank value is held only until the next opcode fetch. This way the redirection covers exactly one indirect instruction. One bank value, 0x8F, does not select a plain bank. It selects a remapped layout that reaches the system bank and a linear RAM window. The translation result is registered. It appears on the outputs in the cycle after the address is presented, and the memory decoder behind the unit uses it from there.

Top module: `xb_unit`

## Requirements
- R1: A capture happens only on a read cycle with `cpu_sync` low and `cpu_addr` below 0x0100, and only while `zp_reg` lies between 0x18 and 0x1F inclusive. A capture loads the bank register from `xbyte_data`. A write, an opcode fetch, or any other zero-page page leaves the bank register unchanged.
- R2: `xbyte_addr` is `{zp_reg, 8'h00}` with bits 11 and 10 inverted, that is, XOR 0x0C00. It changes in the same cycle as `zp_reg`.
- R3: The captured byte is masked with 0x8F before it is stored. Bits 6..4 are always zero, so 0xF5 becomes bank 0x85 and 0x7F becomes 0x0F, which does not translate.
- R4: A cycle is translated (`ext_valid` = 1) only when it is a read or a write, it is not an opcode fetch, bit 7 of the stored bank is set, and `cpu_addr` is 0x0100 or above. A cycle that is not translated drives all outputs to zero.
- R5: Reset and every opcode-fetch cycle clear the stored bank. An opcode-fetch cycle is never translated itself.
- R6: For banks 0x80..0x8E, `ext_bank` is the low nibble of the bank, `ext_off` equals `cpu_addr`, and `ext_sys` = `ext_lin` = 0.
- R7: For bank 0x8F, addresses 0xFFD0..0xFFEF go to the system bank (`ext_sys` = 1) at `cpu_addr & 0x7FFF`.
- R8: For bank 0x8F, other addresses below 0x2000 go to the system bank at `cpu_addr - 0x2000`, taken modulo 2^16.
- R9: For bank 0x8F, other addresses above 0x9FFF go to the system bank at `cpu_addr - 0x8000`.
- R10: For bank 0x8F, addresses 0x2000..0x9FFF go to linear RAM (`ext_lin` = 1) at `cpu_addr - 0x2000`. `ext_bank` reads 0xF for every bank-0x8F access.
- R11: Translation outputs are registered. They reflect the inputs of the previous clock edge. A capture made at one edge already affects the data cycle presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address of the current cycle |
| cpu_rd | input | 1 | Current cycle is a read |
| cpu_wr | input | 1 | Current cycle is a write |
| cpu_sync | input | 1 | Current cycle is an opcode fetch |
| zp_reg | input | 8 | Current zero-page page number |
| xbyte_data | input | 8 | Extension byte returned from `xbyte_addr` |
| xbyte_addr | output | 16 | Address of the extension byte |
| ext_valid | output | 1 | Registered: previous cycle was translated |
| ext_sys | output | 1 | Registered: target is the system bank |
| ext_lin | output | 1 | Registered: target is linear RAM |
| ext_bank | output | 4 | Registered: extended bank number |
| ext_off | output | 16 | Registered: offset within the target |

## Verification
Two functions can fall on the same edge. One is loading a new bank from a zero-page read. The other is clearing the bank on an opcode fetch, which also suppresses translation of that fetch. The bench presents an opcode fetch at a zero-page address while `zp_reg` is in the extended range and `xbyte_data` carries a valid bank. The data cycle that follows must come out untranslated. The bench also presents a capture immediately followed by a data cycle, and that cycle must already use the new bank one register stage later. A reference model, updated once per clock, predicts each registered output, and the bench compares against it on the falling edge.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int XB_AW = 16;
  localparam int XB_DW = 8;
  localparam int XB_BW = 4;

  typedef logic [XB_AW-1:0] addr_t;

  typedef struct packed {
    logic             valid;
    logic             sys;
    logic             lin;
    logic [XB_BW-1:0] bank;
    addr_t            off;
  } xlate_t;

  localparam xlate_t XLATE_NONE = '0;

  // Boundaries of the remapped layout
  localparam addr_t HOLE_LO  = addr_t'(16'hFFD0);
  localparam addr_t HOLE_HI  = addr_t'(16'hFFEF);
  localparam addr_t HOLE_MSK = addr_t'(16'h7FFF);
  localparam addr_t LOW_TOP  = addr_t'(16'h2000);
  localparam addr_t MID_TOP  = addr_t'(16'h9FFF);
  localparam addr_t LOW_SUB  = addr_t'(16'h2000);
  localparam addr_t HIGH_SUB = addr_t'(16'h8000);

  function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // Plain extended bank: offset passes through unchanged
  function automatic xlate_t map_plain(addr_t a, logic [XB_BW-1:0] bnk);
    xlate_t r;
    r       = XLATE_NONE;
    r.valid = 1'b1;
    r.bank  = bnk;
    r.off   = a;
    return r;
  endfunction

  // Remapped layout of the special bank
  function automatic xlate_t map_special(addr_t a, logic [XB_BW-1:0] bnk);
    xlate_t r;
    r       = XLATE_NONE;
    r.valid = 1'b1;
    r.bank  = bnk;
    if (in_window(a, HOLE_LO, HOLE_HI)) begin
      r.sys = 1'b1;
      r.off = a & HOLE_MSK;
    end else if (a < LOW_TOP) begin
      r.sys = 1'b1;
      r.off = a - LOW_SUB;
    end else if (a > MID_TOP) begin
      r.sys = 1'b1;
      r.off = a - HIGH_SUB;
    end else begin
      r.lin = 1'b1;
      r.off = a - LOW_SUB;
    end
    return r;
  endfunction
endpackage

// File: rtl/xb_capture.sv
module xb_capture
  import xb_pkg::*;
#(
  parameter logic [XB_DW-1:0] ZP_LO     = 8'h18,
  parameter logic [XB_DW-1:0] ZP_HI     = 8'h1F,
  parameter logic [XB_DW-1:0] KEEP_MASK = 8'h8F,
  parameter int               PAGE_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_rd,
  input  logic             cpu_sync,
  input  addr_t            cpu_addr,
  input  logic [XB_DW-1:0] zp_reg,
  input  logic [XB_DW-1:0] xbyte_data,
  output logic [XB_DW-1:0] bank_q,
  output logic [XB_DW-1:0] bank_eff,
  output logic             cap_fire
);
  localparam int HI_W = XB_AW - PAGE_W;

  logic zp_page;
  logic zp_in_range;

  assign zp_page     = (cpu_addr[XB_AW-1:PAGE_W] == '0);
  assign zp_in_range = (zp_reg >= ZP_LO) && (zp_reg <= ZP_HI);
  assign cap_fire    = cpu_rd && !cpu_sync && zp_page && zp_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (cpu_sync) begin
      bank_q <= '0;
    end else if (cap_fire) begin
      bank_q <= xbyte_data & KEEP_MASK;
    end
  end

  // An opcode fetch sees the bank already cleared
  assign bank_eff = cpu_sync ? '0 : bank_q;

  if (HI_W <= 0) begin : g_bad_page
    initial $error("xb_capture: PAGE_W must be below the address width");
  end
endmodule

// File: rtl/xb_translate.sv
module xb_translate
  import xb_pkg::*;
#(
  parameter logic [XB_BW-1:0] SPECIAL_BANK = 4'hF,
  parameter bit               HAS_SPECIAL  = 1'b1,
  parameter int               PAGE_W       = 8
) (
  input  logic             access,
  input  logic             bank_on,
  input  logic [XB_BW-1:0] bank_num,
  input  addr_t            cpu_addr,
  output logic             ext_hit,
  output xlate_t           result
);
  logic above_zp;
  logic is_special;

  assign above_zp = (cpu_addr[XB_AW-1:PAGE_W] != '0);
  assign ext_hit  = access && bank_on && above_zp;

  if (HAS_SPECIAL) begin : g_special
    assign is_special = (bank_num == SPECIAL_BANK);
  end else begin : g_no_special
    assign is_special = 1'b0;
  end

  always_comb begin
    if (!ext_hit) begin
      result = XLATE_NONE;
    end else if (is_special) begin
      result = map_special(cpu_addr, bank_num);
    end else begin
      result = map_plain(cpu_addr, bank_num);
    end
  end
endmodule

// File: rtl/xb_outreg.sv
module xb_outreg
  import xb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  xlate_t d,
  output xlate_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= XLATE_NONE;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/xb_unit.sv
module xb_unit
  import xb_pkg::*;
#(
  parameter logic [XB_DW-1:0] ZP_LO        = 8'h18,
  parameter logic [XB_DW-1:0] ZP_HI        = 8'h1F,
  parameter logic [XB_DW-1:0] KEEP_MASK    = 8'h8F,
  parameter logic [XB_AW-1:0] SHADOW_XOR   = 16'h0C00,
  parameter logic [XB_BW-1:0] SPECIAL_BANK = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic        cpu_sync,
  input  logic [7:0]  zp_reg,
  input  logic [7:0]  xbyte_data,
  output logic [15:0] xbyte_addr,
  output logic        ext_valid,
  output logic        ext_sys,
  output logic        ext_lin,
  output logic [3:0]  ext_bank,
  output logic [15:0] ext_off
);
  localparam int PAGE_W = XB_AW - XB_DW;
  localparam int TOP_BIT = XB_DW - 1;

  logic [XB_DW-1:0] bank_q;
  logic [XB_DW-1:0] bank_eff;
  logic             cap_fire;
  logic             ext_hit;
  logic             access;
  xlate_t           xl_d;
  xlate_t           xl_q;

  assign access     = cpu_rd || cpu_wr;
  assign xbyte_addr = {zp_reg, {PAGE_W{1'b0}}} ^ SHADOW_XOR;

  xb_capture #(
    .ZP_LO    (ZP_LO),
    .ZP_HI    (ZP_HI),
    .KEEP_MASK(KEEP_MASK),
    .PAGE_W   (PAGE_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_sync  (cpu_sync),
    .cpu_addr  (cpu_addr),
    .zp_reg    (zp_reg),
    .xbyte_data(xbyte_data),
    .bank_q    (bank_q),
    .bank_eff  (bank_eff),
    .cap_fire  (cap_fire)
  );

  xb_translate #(
    .SPECIAL_BANK(SPECIAL_BANK),
    .HAS_SPECIAL (1'b1),
    .PAGE_W      (PAGE_W)
  ) u_translate (
    .access  (access),
    .bank_on (bank_eff[TOP_BIT]),
    .bank_num(bank_eff[XB_BW-1:0]),
    .cpu_addr(cpu_addr),
    .ext_hit (ext_hit),
    .result  (xl_d)
  );

  xb_outreg u_outreg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (xl_d),
    .q    (xl_q)
  );

  assign ext_valid = xl_q.valid;
  assign ext_sys   = xl_q.sys;
  assign ext_lin   = xl_q.lin;
  assign ext_bank  = xl_q.bank;
  assign ext_off   = xl_q.off;
endmodule

// File: rtl/xb_unit_chk.sv
module xb_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_sync,
  input logic [15:0] cpu_addr,
  input logic [7:0]  xbyte_data,
  input logic        cap_fire,
  input logic        ext_hit,
  input logic [7:0]  bank_q,
  input logic        ext_valid,
  input logic        ext_sys,
  input logic        ext_lin
);
  // R1 and R3: a capture loads the masked extension byte
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (bank_q == ($past(xbyte_data) & 8'h8F)));

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q & 8'h70) == 8'h00);

  // R4: zero-page addresses never come out translated
  p_no_zp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> ($past(cpu_addr) >= 16'h0100));

  // R11: registered output follows the hit of the previous cycle
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> ext_valid);

  // R5: an opcode fetch clears the bank and is not translated
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sync |=> (bank_q == 8'h00) && !ext_valid);

  // R10: a target is either system bank or linear RAM, never both
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_sys && ext_lin));

  p_sys_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sys || ext_lin) |-> ext_valid);
endmodule

bind xb_unit xb_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_sync  (cpu_sync),
  .cpu_addr  (cpu_addr),
  .xbyte_data(xbyte_data),
  .cap_fire  (cap_fire),
  .ext_hit   (ext_hit),
  .bank_q    (bank_q),
  .ext_valid (ext_valid),
  .ext_sys   (ext_sys),
  .ext_lin   (ext_lin)
);

// File: tb/xb_unit_tb.sv
`timescale 1ns/1ps
module xb_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_sync = 1'b0;
  logic [7:0]  zp_reg = '0, xbyte_data = '0;
  logic [15:0] xbyte_addr;
  logic        ext_valid, ext_sys, ext_lin;
  logic [3:0]  ext_bank;
  logic [15:0] ext_off;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int    m_bank = 0;
  bit    e_valid, e_sys, e_lin;
  int    e_bank, e_off;
  string e_tag = "R5";

  always #2 clk = ~clk;

  xb_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_sync(cpu_sync), .zp_reg(zp_reg),
    .xbyte_data(xbyte_data), .xbyte_addr(xbyte_addr), .ext_valid(ext_valid),
    .ext_sys(ext_sys), .ext_lin(ext_lin), .ext_bank(ext_bank), .ext_off(ext_off)
  );

  task automatic check_out(input string tag);
    n_chk++;
    if (ext_valid !== e_valid || ext_sys !== e_sys || ext_lin !== e_lin ||
        int'(ext_bank) != e_bank || int'(ext_off) != e_off) begin
      n_fail++;
      $display("FAIL %s: got v%0b s%0b l%0b bank %h off %h, exp v%0b s%0b l%0b bank %h off %h",
               tag, ext_valid, ext_sys, ext_lin, ext_bank, ext_off,
               e_valid, e_sys, e_lin, e_bank[3:0], e_off[15:0]);
    end
  endtask

  task automatic clear_exp();
    e_valid = 0; e_sys = 0; e_lin = 0; e_bank = 0; e_off = 0;
  endtask

  // Predict the registered result of one bus cycle, then advance the bank
  task automatic model(input int a, input bit rd, input bit wr, input bit sy,
                       input int zp, input int xd);
    int eff;
    eff = sy ? 0 : m_bank;
    clear_exp();
    e_tag = sy ? "R5" : "R4";
    if ((rd || wr) && eff >= 128 && a >= 256) begin
      e_valid = 1;
      e_bank  = eff % 16;
      if (e_bank == 15) begin
        if (a >= 'hFFD0 && a <= 'hFFEF) begin
          e_sys = 1; e_off = a % 32768; e_tag = "R7";
        end else if (a < 'h2000) begin
          e_sys = 1; e_off = (a + 65536 - 8192) % 65536; e_tag = "R8";
        end else if (a > 'h9FFF) begin
          e_sys = 1; e_off = a - 32768; e_tag = "R9";
        end else begin
          e_lin = 1; e_off = a - 8192; e_tag = "R10";
        end
      end else begin
        e_off = a; e_tag = "R6";
      end
    end
    if (sy) m_bank = 0;
    else if (rd && a < 256 && zp >= 24 && zp <= 31)
      m_bank = (xd / 128) * 128 + (xd % 16);   // R1, R3: keep bit 7 and low nibble
  endtask

  // One bus cycle, entered and left on a falling edge
  task automatic cyc(input int a, input bit rd, input bit wr, input bit sy,
                     input int zp, input int xd);
    int xa;
    check_out(e_tag);
    cpu_addr = a[15:0]; cpu_rd = rd; cpu_wr = wr; cpu_sync = sy;
    zp_reg = zp[7:0]; xbyte_data = xd[7:0];
    #1;
    check_out("R11");                       // outputs hold until the edge
    xa = (zp * 256) ^ 'h0C00;
    n_chk++;
    if (int'(xbyte_addr) != xa) begin       // R2
      n_fail++;
      $display("FAIL R2: xbyte_addr %h exp %h", xbyte_addr, xa[15:0]);
    end
    model(a, rd, wr, sy, zp, xd);
    @(negedge clk);
  endtask

  task automatic idle(); cyc(16'h4000, 0, 0, 0, 'h18, 0); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    clear_exp();
    repeat (3) @(negedge clk);
    check_out("R5");                        // reset state
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R6 R11: fetch, capture 0x83, then data cycles in bank 3
    cyc('h0300, 1, 0, 1, 'h1A, 'h00);
    cyc('h0012, 1, 0, 0, 'h1A, 'h83);
    cyc('h4567, 1, 0, 0, 'h1A, 'h00);
    cyc('h0100, 0, 1, 0, 'h1A, 'h00);       // R4 boundary: translated
    cyc('h00FF, 0, 1, 0, 'h1A, 'hFF);       // R4 zero page write: no capture, untranslated
    cyc('hFFFF, 1, 0, 0, 'h1A, 'h00);       // R6 still bank 3
    cyc('h5000, 0, 0, 0, 'h1A, 'h00);       // R4 no access
    // R5: fetch at zero page with valid byte present does not capture
    cyc('h0040, 1, 0, 1, 'h1C, 'h8E);
    cyc('h4000, 1, 0, 0, 'h1C, 'h00);
    // R1: out-of-range pages do not capture
    cyc('h0010, 1, 0, 0, 'h17, 'h85);
    cyc('h4000, 1, 0, 0, 'h17, 'h00);
    cyc('h0010, 1, 0, 0, 'h20, 'h85);
    cyc('h4000, 1, 0, 0, 'h20, 'h00);
    // R3: 0xF5 -> bank 0x85
    cyc('h0010, 1, 0, 0, 'h18, 'hF5);
    cyc('h1234, 0, 1, 0, 'h18, 'h00);
    // R3: 0x7F -> 0x0F, no translation
    cyc('h0011, 1, 0, 0, 'h1F, 'h7F);
    cyc('h1234, 1, 0, 0, 'h1F, 'h00);
    // R6: 0x8E plain
    cyc('h0011, 1, 0, 0, 'h1F, 'h8E);
    cyc('hFFE0, 1, 0, 0, 'h1F, 'h00);
    // R7..R10: special bank 0x8F (0xFF masked)
    cyc('h0020, 1, 0, 0, 'h1B, 'hFF);
    cyc('hFFD0, 1, 0, 0, 'h1B, 0);
    cyc('hFFEF, 0, 1, 0, 'h1B, 0);
    cyc('hFFCF, 1, 0, 0, 'h1B, 0);
    cyc('hFFF0, 1, 0, 0, 'h1B, 0);
    cyc('h0100, 1, 0, 0, 'h1B, 0);
    cyc('h1FFF, 1, 0, 0, 'h1B, 0);
    cyc('h2000, 1, 0, 0, 'h1B, 0);
    cyc('h9FFF, 0, 1, 0, 'h1B, 0);
    cyc('hA000, 1, 0, 0, 'h1B, 0);
    cyc('hC000, 1, 0, 0, 'h1B, 0);
    // R5: reset in the middle clears the bank
    rst_n = 1'b0;
    clear_exp(); m_bank = 0;
    @(negedge clk);
    check_out("R5");
    rst_n = 1'b1;
    @(negedge clk);
    cyc('h3000, 1, 0, 0, 'h1B, 0);
    // R11: back-to-back capture then data, bank switched between them
    cyc('h0001, 1, 0, 0, 'h19, 'h81);
    cyc('h0002, 1, 0, 0, 'h19, 'h82);
    cyc('h7777, 1, 0, 0, 'h19, 0);
    idle();
    idle();
    check_out(e_tag);
    done = 1;
    summary();
    $finish;
  end
endmodule